// File: doc/BRIEF.md
# Exception Return Unstacker

This block sits beside the program-counter write path of a small embedded core. Every value that any instruction puts into the program counter is presented to it on one write port. These include register branches, pops into the program counter and loads of the program counter from memory, and the core merges all of them onto that port. A value whose upper bits carry the return signature is taken as a return command and not as a branch. The block decodes the low bits of that value to find the mode to resume in and the stack pointer to unwind.

For a well-formed return command the block reads the saved eight-word frame back through a memory read port. It reads from the bottom of the frame upward. Each word is handed to the register file for its slot as it arrives, and the selected stack pointer is moved up one word at a time. After the last word the block pulses a completion strobe, which also tells the interrupt controller to drop the active flag of the running exception. A value with the signature but bad reserved bits, or one that asks for a floating-point frame, is only flagged. Any other value goes straight out as a normal branch target.

Top module: `exc_return_unit`

## Requirements
- R1: A program-counter write whose bits 31..5 are not all ones is passed out as a branch in the same cycle: `branch_valid` high and `branch_target` equal to the written value, with no error flag and no memory read.
- R2: A write with bits 31..5 all ones, bit 4 = 1, bit 1 = 0 and bit 0 = 1 is a valid return command. It raises no branch and no error, and `busy` is high from the next cycle.
- R3: Bit 2 of a valid command selects the stack to unwind: 1 = process stack pointer (`psp_cur`), 0 = main stack pointer (`msp_cur`). The value is sampled in the command cycle, and `sp_wr_psp` and `ret_psp` report the choice.
- R4: The frame is read in ascending address order. Read k (k = 0..7) is at address base + 4k, and its data goes to slot k. Slots 0..7 are R0, R1, R2, R3, R12, LR, PC, xPSR.
- R5: In every cycle where `mem_rd_ack` is high during unstacking, `reg_wr_valid` is high in that same cycle. `reg_wr_slot` then gives the slot and `reg_wr_data` equals `mem_rd_data`.
- R6: With each accepted read, `sp_wr_valid` is high and `sp_wr_value` = base + 4(k+1). The final write is therefore base + 32.
- R7: In the cycle after the eighth read, `ret_done` and `active_clr` pulse together for one cycle, with `ret_thread` equal to bit 3 of the command (1 = thread mode, 0 = handler mode). `busy` is low in the cycle after that.
- R8: A write with bits 31..5 all ones that has bit 4 = 0, bit 1 = 1, or bit 0 = 0 raises `token_err` in the same cycle. It gives no branch and no memory read, and `busy` stays low.
- R9: While unstacking is in progress, program-counter writes are ignored. They produce no branch and no error, and the frame sequence is unchanged.
- R10: `mem_rd_req` with `mem_rd_addr` stays stable until it is acknowledged, so any number of wait states is allowed.
- R11: After reset `busy`, `mem_rd_req`, `ret_done` and `active_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_wr_valid | input | 1 | A value is being written to the program counter |
| pc_wr_value | input | 32 | Value written to the program counter |
| msp_cur | input | 32 | Current main stack pointer |
| psp_cur | input | 32 | Current process stack pointer |
| branch_valid | output | 1 | Normal branch passed through |
| branch_target | output | 32 | Target of the passed-through branch |
| token_err | output | 1 | Malformed or floating-point return command |
| mem_rd_req | output | 1 | Frame read request |
| mem_rd_addr | output | 32 | Frame read byte address |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Read data |
| reg_wr_valid | output | 1 | Restore one frame register |
| reg_wr_slot | output | 3 | Frame slot being restored (0 = R0 … 7 = xPSR) |
| reg_wr_data | output | 32 | Restored value |
| sp_wr_valid | output | 1 | Stack pointer update |
| sp_wr_psp | output | 1 | Update targets the process stack pointer |
| sp_wr_value | output | 32 | New stack pointer value |
| ret_done | output | 1 | Return completed (one-cycle pulse) |
| ret_thread | output | 1 | Resume in thread mode |
| ret_psp | output | 1 | Resume on the process stack |
| active_clr | output | 1 | Clear the active exception in the interrupt controller |
| busy | output | 1 | Unstacking in progress |

## Verification
All four legal command encodings are run: thread or handler mode, each on the process or main stack. These runs separate the decode of bit 3 from that of bit 2, because each combination gives a different base address and mode result. Near-miss values are also applied. One has bit 5 clear, which must branch. Others have the signature but bit 4 clear, bit 1 set or bit 0 clear, which must flag an error. Together these pin down where the signature ends and which reserved bits are checked. Read latencies of zero and several wait states, and a stray program-counter write in the middle of a frame, show that slot order, data and stack pointer steps follow the acknowledges and not the cycle count.

// File: rtl/exr_pkg.sv
package exr_pkg;
  localparam int XLEN      = 32;
  localparam int SIG_LSB   = 5;
  localparam int WORD_BYTES = 4;

  // token bit positions
  localparam int B_NOFP   = 4;
  localparam int B_THREAD = 3;
  localparam int B_PSP    = 2;
  localparam int B_RSV1   = 1;
  localparam int B_RSV0   = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_FIN} exr_state_e;

  typedef struct packed {
    logic hit;      // signature present
    logic good;     // well-formed, integer-only frame
    logic thread;
    logic psp;
  } exr_tok_t;

  function automatic logic sig_match(input logic [XLEN-1:0] v);
    return &v[XLEN-1:SIG_LSB];
  endfunction

  function automatic logic fmt_ok(input logic [XLEN-1:0] v);
    return v[B_NOFP] && !v[B_RSV1] && v[B_RSV0];
  endfunction

  // byte address of a frame slot counted from the frame base
  function automatic logic [XLEN-1:0] slot_addr(input logic [XLEN-1:0] base,
                                                input logic [XLEN-1:0] slot);
    return base + slot * WORD_BYTES;
  endfunction
endpackage

// File: rtl/exr_token_decode.sv
module exr_token_decode
  import exr_pkg::*;
(
  input  logic [XLEN-1:0] value,
  output exr_tok_t        tok
);
  always_comb begin
    tok.hit    = sig_match(value);
    tok.good   = tok.hit && fmt_ok(value);
    tok.thread = value[B_THREAD];
    tok.psp    = value[B_PSP];
  end
endmodule

// File: rtl/exr_sp_select.sv
module exr_sp_select
  import exr_pkg::*;
(
  input  logic            use_psp,
  input  logic [XLEN-1:0] msp,
  input  logic [XLEN-1:0] psp,
  output logic [XLEN-1:0] sp
);
  assign sp = use_psp ? psp : msp;
endmodule

// File: rtl/exr_unstack_seq.sv
module exr_unstack_seq
  import exr_pkg::*;
#(
  parameter int FRAME_WORDS = 8,
  localparam int IDX_W = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [XLEN-1:0]  start_base,
  input  logic             start_psp,
  input  logic             start_thread,
  input  logic             rd_ack,
  output logic             idle,
  output logic             rd_req,
  output logic [XLEN-1:0]  rd_addr,
  output logic             step,
  output logic [IDX_W-1:0] slot,
  output logic [XLEN-1:0]  sp_next,
  output logic             finish,
  output logic             sel_psp,
  output logic             sel_thread
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_WORDS - 1);

  exr_state_e      state;
  logic [XLEN-1:0] base;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      base       <= '0;
      cnt        <= '0;
      sel_psp    <= 1'b0;
      sel_thread <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state      <= ST_READ;
          base       <= start_base;
          cnt        <= '0;
          sel_psp    <= start_psp;
          sel_thread <= start_thread;
        end
        ST_READ: if (rd_ack) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (state == ST_IDLE);
  assign rd_req  = (state == ST_READ);
  assign rd_addr = slot_addr(base, XLEN'(cnt));
  assign step    = rd_req && rd_ack;
  assign slot    = cnt;
  assign sp_next = slot_addr(base, XLEN'(cnt) + 1);
  assign finish  = (state == ST_FIN);
endmodule

// File: rtl/exc_return_unit.sv
module exc_return_unit
  import exr_pkg::*;
#(
  parameter int FRAME_WORDS = 8,
  localparam int IDX_W = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_wr_valid,
  input  logic [31:0]      pc_wr_value,
  input  logic [31:0]      msp_cur,
  input  logic [31:0]      psp_cur,
  output logic             branch_valid,
  output logic [31:0]      branch_target,
  output logic             token_err,
  output logic             mem_rd_req,
  output logic [31:0]      mem_rd_addr,
  input  logic             mem_rd_ack,
  input  logic [31:0]      mem_rd_data,
  output logic             reg_wr_valid,
  output logic [IDX_W-1:0] reg_wr_slot,
  output logic [31:0]      reg_wr_data,
  output logic             sp_wr_valid,
  output logic             sp_wr_psp,
  output logic [31:0]      sp_wr_value,
  output logic             ret_done,
  output logic             ret_thread,
  output logic             ret_psp,
  output logic             active_clr,
  output logic             busy
);
  exr_tok_t        tok;
  logic            idle;
  logic            accept;
  logic            start;
  logic [XLEN-1:0] base_sel;
  logic            step;
  logic            finish;
  logic            sel_psp;
  logic            sel_thread;
  logic [XLEN-1:0] sp_next;

  exr_token_decode u_dec (.value(pc_wr_value), .tok(tok));

  exr_sp_select u_sp (
    .use_psp(tok.psp), .msp(msp_cur), .psp(psp_cur), .sp(base_sel)
  );

  assign accept = pc_wr_valid && idle;
  assign start  = accept && tok.good;

  exr_unstack_seq #(.FRAME_WORDS(FRAME_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_base(base_sel),
    .start_psp(tok.psp), .start_thread(tok.thread),
    .rd_ack(mem_rd_ack),
    .idle(idle), .rd_req(mem_rd_req), .rd_addr(mem_rd_addr),
    .step(step), .slot(reg_wr_slot), .sp_next(sp_next),
    .finish(finish), .sel_psp(sel_psp), .sel_thread(sel_thread)
  );

  assign branch_valid  = accept && !tok.hit;
  assign branch_target = pc_wr_value;
  assign token_err     = accept && tok.hit && !tok.good;

  assign reg_wr_valid = step;
  assign reg_wr_data  = mem_rd_data;
  assign sp_wr_valid  = step;
  assign sp_wr_psp    = sel_psp;
  assign sp_wr_value  = sp_next;

  assign ret_done   = finish;
  assign active_clr = finish;
  assign ret_thread = sel_thread;
  assign ret_psp    = sel_psp;
  assign busy       = !idle;
endmodule

// File: rtl/exr_checker.sv
module exr_checker #(
  parameter int FRAME_WORDS = 8,
  localparam int IDX_W = $clog2(FRAME_WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pc_wr_valid,
  input logic [31:0]      pc_wr_value,
  input logic             branch_valid,
  input logic             token_err,
  input logic             mem_rd_req,
  input logic [31:0]      mem_rd_addr,
  input logic             mem_rd_ack,
  input logic             reg_wr_valid,
  input logic [IDX_W-1:0] reg_wr_slot,
  input logic             sp_wr_valid,
  input logic             ret_done,
  input logic             active_clr,
  input logic             busy
);
  logic [IDX_W:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (ret_done) seen <= '0;
    else if (reg_wr_valid) seen <= seen + 1'b1;
  end

  assert_branch_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_valid && !busy && !(&pc_wr_value[31:5])) |-> branch_valid);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_valid && !busy && !branch_valid && !token_err) |=> busy);

  assert_slot_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |-> ({1'b0, reg_wr_slot} == seen));

  assert_restore_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_ack) |-> reg_wr_valid);

  assert_sp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_valid |-> reg_wr_valid);

  assert_done_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |-> (active_clr && seen == (IDX_W+1)'(FRAME_WORDS)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |=> (!ret_done && !busy));

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    token_err |=> !busy);

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!branch_valid && !token_err));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));
endmodule

bind exc_return_unit exr_checker #(.FRAME_WORDS(FRAME_WORDS)) u_exr_chk (
  .clk(clk), .rst_n(rst_n), .pc_wr_valid(pc_wr_valid), .pc_wr_value(pc_wr_value),
  .branch_valid(branch_valid), .token_err(token_err), .mem_rd_req(mem_rd_req),
  .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .reg_wr_valid(reg_wr_valid),
  .reg_wr_slot(reg_wr_slot), .sp_wr_valid(sp_wr_valid), .ret_done(ret_done),
  .active_clr(active_clr), .busy(busy)
);

// File: tb/test_exc_return_unit.sv
module test_exc_return_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pc_wr_valid = 1'b0;
  logic [31:0] pc_wr_value = '0;
  logic [31:0] msp_cur = 32'h2001_0000;
  logic [31:0] psp_cur = 32'h2000_4000;
  logic        branch_valid, token_err, mem_rd_req, reg_wr_valid;
  logic [31:0] branch_target, mem_rd_addr, reg_wr_data, sp_wr_value;
  logic        mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic [2:0]  reg_wr_slot;
  logic        sp_wr_valid, sp_wr_psp, ret_done, ret_thread, ret_psp, active_clr, busy;

  int checks = 0;
  int errors = 0;
  int lat_cfg = 0;
  int wcnt = 0;
  bit hung = 1'b0;

  exc_return_unit i_exc_return_unit (
    .clk(clk), .rst_n(rst_n), .pc_wr_valid(pc_wr_valid), .pc_wr_value(pc_wr_value),
    .msp_cur(msp_cur), .psp_cur(psp_cur), .branch_valid(branch_valid),
    .branch_target(branch_target), .token_err(token_err), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_slot(reg_wr_slot), .reg_wr_data(reg_wr_data),
    .sp_wr_valid(sp_wr_valid), .sp_wr_psp(sp_wr_psp), .sp_wr_value(sp_wr_value),
    .ret_done(ret_done), .ret_thread(ret_thread), .ret_psp(ret_psp),
    .active_clr(active_clr), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // stack contents: derived from the address in a way unlike the RTL
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A00_00C3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder: acks after lat_cfg wait cycles
  initial forever begin
    @(negedge clk);
    if (mem_rd_ack) mem_rd_ack = 1'b0;
    else if (mem_rd_req) begin
      if (wcnt >= lat_cfg) begin
        mem_rd_ack  = 1'b1;
        mem_rd_data = mem_word(mem_rd_addr);
        wcnt = 0;
      end else wcnt++;
    end
  end

  task automatic drive_pc(input logic [31:0] v);
    @(negedge clk);
    pc_wr_valid = 1'b1;
    pc_wr_value = v;
    #2;
  endtask

  task automatic release_pc();
    @(negedge clk);
    pc_wr_valid = 1'b0;
  endtask

  task automatic t_branch(input logic [31:0] v);
    drive_pc(v);
    check("R1 branch_valid", 32'(branch_valid), 32'd1);
    check("R1 branch_target", branch_target, v);
    check("R1 token_err", 32'(token_err), 32'd0);
    release_pc();
    #2;
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 mem_rd_req", 32'(mem_rd_req), 32'd0);
  endtask

  task automatic t_bad(input logic [31:0] v);
    drive_pc(v);
    check("R8 token_err", 32'(token_err), 32'd1);
    check("R8 branch_valid", 32'(branch_valid), 32'd0);
    release_pc();
    #2;
    check("R8 busy", 32'(busy), 32'd0);
    check("R8 mem_rd_req", 32'(mem_rd_req), 32'd0);
  endtask

  task automatic t_return(input logic [31:0] tok, input int lat, input bit stray);
    logic [31:0] base;
    int k;
    int guard;
    lat_cfg = lat;
    base = tok[2] ? psp_cur : msp_cur;
    drive_pc(tok);
    check("R2 branch_valid", 32'(branch_valid), 32'd0);
    check("R2 token_err", 32'(token_err), 32'd0);
    release_pc();
    #2;
    check("R2 busy", 32'(busy), 32'd1);
    check("R3 first addr", mem_rd_addr, base);
    k = 0;
    guard = 0;
    while (k < 8 && guard < 200) begin
      if (reg_wr_valid) begin
        check("R4 addr", mem_rd_addr, base + 32'(4*k));
        check("R4 slot", 32'(reg_wr_slot), 32'(k));
        check("R5 data", reg_wr_data, mem_word(base + 32'(4*k)));
        check("R6 sp valid", 32'(sp_wr_valid), 32'd1);
        check("R6 sp value", sp_wr_value, base + 32'(4*(k+1)));
        check("R3 sp sel", 32'(sp_wr_psp), 32'(tok[2]));
        k++;
      end else if (mem_rd_req) begin
        check("R10 hold addr", mem_rd_addr, base + 32'(4*k));
      end
      if (stray && k == 3) begin
        @(negedge clk);
        pc_wr_valid = 1'b1;
        pc_wr_value = 32'h0800_1234;
        #2;
        check("R9 no branch", 32'(branch_valid), 32'd0);
        check("R9 no err", 32'(token_err), 32'd0);
        pc_wr_value = 32'hFFFF_FFFF;
        #1;
        check("R9 no err bad", 32'(token_err), 32'd0);
        #0;
        stray = 1'b0;
        // leave valid high one cycle, then drop
        if (reg_wr_valid) ; // sample handled by loop
        @(negedge clk);
        pc_wr_valid = 1'b0;
        #2;
        continue;
      end
      @(negedge clk);
      #2;
      guard++;
    end
    check("R4 eight reads", 32'(k), 32'd8);
    check("R7 ret_done", 32'(ret_done), 32'd1);
    check("R7 active_clr", 32'(active_clr), 32'd1);
    check("R7 ret_thread", 32'(ret_thread), 32'(tok[3]));
    check("R3 ret_psp", 32'(ret_psp), 32'(tok[2]));
    @(negedge clk);
    #2;
    check("R7 busy low", 32'(busy), 32'd0);
    check("R7 done pulse", 32'(ret_done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    hung = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R11 busy", 32'(busy), 32'd0);
    check("R11 mem_rd_req", 32'(mem_rd_req), 32'd0);
    check("R11 ret_done", 32'(ret_done), 32'd0);
    check("R11 active_clr", 32'(active_clr), 32'd0);
    rst_n = 1'b1;
    t_branch(32'h0800_0123);
    t_branch(32'hFFFF_FFDD);           // bit 5 clear
    t_bad(32'hFFFF_FFE1);              // bit 4 clear
    t_bad(32'hFFFF_FFFF);              // bit 1 set
    t_bad(32'hFFFF_FFFC);              // bit 0 clear
    t_return(32'hFFFF_FFFD, 0, 1'b0);  // thread, process stack
    t_return(32'hFFFF_FFF9, 2, 1'b0);  // thread, main stack
    t_return(32'hFFFF_FFF1, 1, 1'b1);  // handler, main stack, stray write
    psp_cur = 32'h2000_3F00;
    t_return(32'hFFFF_FFF5, 3, 1'b0);  // handler, process stack
    t_branch(32'h0000_0040);
    if (!hung) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule